// File: doc/BRIEF.md
# Processor Sleep and Wake Controller

This block decides, cycle by cycle, whether a processor core is asleep. Three things put the core to sleep: a wait-for-interrupt request, a wait-for-event request, or a return from an exception handler to thread level while the auto-sleep bit is set. While the core sleeps, the block watches the interrupt pending, enable and priority summaries, the current execution priority, an external event pulse and a debug request. When a wake condition holds, it issues a one-cycle wake strobe. The wait-for-interrupt rules and the wait-for-event rules differ. Wait-for-event also has an internal event latch, which remembers an event that arrived while the core was awake.

A small control register sets the policy, and only privileged writes reach it. Its fields are: auto-sleep on exception return, deep-sleep select, and event-on-new-pend. With event-on-new-pend set, any interrupt whose pending bit rises from 0 to 1 counts as an event, even when the interrupt is disabled or its priority is too low. The deep-sleep output tells the power logic which depth of sleep the core is in.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: The control register has three read/write fields, all 0 after reset: event-on-new-pend at bit 4, deep-sleep select at bit 2 and auto-sleep-on-exit at bit 1. All other bits read as 0.
- R2: A write changes the register only when `reg_wr_priv` is 1 in the write cycle. An unprivileged write leaves the read value unchanged.
- R3: While awake, a wait-for-interrupt request always makes `sleeping` 1 after the next clock edge. Such a sleep ignores the external event input.
- R4: While awake, a wait-for-event request with the event latch set clears the latch, and the core stays awake. The same request with the latch clear makes `sleeping` 1 after the next clock edge.
- R5: While awake, an `ext_event` pulse sets the event latch, and so does a 0-to-1 pending edge when event-on-new-pend is 1. A pending bit that stays at 1 sets nothing further.
- R6: In every kind of sleep, an interrupt wakes the core only when it is pending and enabled and its priority value is strictly lower than `cur_prio` (a lower value means more urgent).
- R7: A wait-for-event sleep also wakes on `ext_event`, on a set event latch, and, when event-on-new-pend is 1, on a 0-to-1 pending edge of any interrupt, including a disabled or low-priority one.
- R8: `dbg_req` wakes any sleep. Reset clears `sleeping`.
- R9: With auto-sleep-on-exit set, an `exc_ret` strobe while awake makes `sleeping` 1 after the next clock edge. With the bit clear, the strobe has no effect.
- R10: `deep_sleep` is 1 exactly when `sleeping` is 1 and deep-sleep select is 1.
- R11: `wake` is 1 only in the last sleeping cycle, from the wake condition in that cycle. `sleeping` falls at the next edge, so `wake` lasts one cycle.
- R12: If wait-for-interrupt and wait-for-event arrive together, wait-for-interrupt wins and the event latch is kept. Sleep requests and `exc_ret` while sleeping are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_priv | input | 1 | Write is issued in privileged state |
| reg_wr_data | input | 8 | Write data |
| reg_rd_data | output | 8 | Control register read value |
| wfi_req | input | 1 | Wait-for-interrupt request |
| wfe_req | input | 1 | Wait-for-event request |
| exc_ret | input | 1 | Return from handler to thread level |
| irq_pend | input | NUM_IRQ | Pending bit per interrupt |
| irq_en | input | NUM_IRQ | Enable bit per interrupt |
| irq_prio | input | NUM_IRQ*PRIO_W | Priority per interrupt, interrupt i at bits [i*PRIO_W +: PRIO_W] |
| cur_prio | input | PRIO_W | Current execution priority |
| ext_event | input | 1 | External event pulse |
| dbg_req | input | 1 | Debug request |
| sleeping | output | 1 | Core is asleep |
| deep_sleep | output | 1 | Sleep is the deep kind |
| wake | output | 1 | One-cycle wake strobe |

## Verification
The register read value, the sleep entry, the latch consume and the pend-edge detection each take one clock edge. The bench drives a request, waits one edge, and samples one time unit after that edge. `wake` and `deep_sleep` come from combinational logic on the current state. The bench checks them one time unit after it drives the wake source, in the same cycle, and then checks that `sleeping` has fallen after the next edge. The priority rule is swept over every pair of interrupt priority and current priority, with the interrupt both enabled and disabled. The register is swept over all byte values.

// File: rtl/sw_pkg.sv
// Package: shared types and field positions for the sleep and wake controller.
// Assumes: an 8-bit control register whose field positions are fixed.
package sw_pkg;
    localparam int CTRL_W       = 8;
    localparam int SEV_BIT      = 4;
    localparam int DEEP_BIT     = 2;
    localparam int SOE_BIT      = 1;
    localparam logic [CTRL_W-1:0] CTRL_MASK =
        CTRL_W'((1 << SEV_BIT) | (1 << DEEP_BIT) | (1 << SOE_BIT));

    typedef enum logic {
        MODE_INT = 1'b0,   // woken by interrupts and debug only
        MODE_EVT = 1'b1    // also woken by events
    } sleep_mode_e;

    typedef struct packed {
        logic sev_on_pend;
        logic deep_sel;
        logic sleep_on_exit;
    } ctrl_t;
endpackage

// File: rtl/sw_ctrl_reg.sv
// Module: privileged control register holding the three sleep policy fields.
// Assumes: only privileged writes are accepted; bits outside the mask read 0.
module sw_ctrl_reg
    import sw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_priv,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output ctrl_t             ctrl
);
    logic [CTRL_W-1:0] reg_q;

    // Store masked write data on a privileged write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_q <= '0;
        else if (wr_en && wr_priv)
            reg_q <= wr_data & CTRL_MASK;
    end

    assign rd_data            = reg_q;
    assign ctrl.sev_on_pend   = reg_q[SEV_BIT];
    assign ctrl.deep_sel      = reg_q[DEEP_BIT];
    assign ctrl.sleep_on_exit = reg_q[SOE_BIT];

    assert_unpriv_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_priv) |=> $stable(rd_data));
endmodule

// File: rtl/sw_irq_eval.sv
// Module: finds whether any interrupt is pending, enabled and more urgent than
// the current level. Assumes: lower priority value means higher urgency.
module sw_irq_eval #(
    parameter int NUM_IRQ = 4,
    parameter int PRIO_W  = 3
) (
    input  logic [NUM_IRQ-1:0]        pend,
    input  logic [NUM_IRQ-1:0]        en,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]         cur_prio,
    output logic                      qual_any
);
    logic [NUM_IRQ-1:0] qual;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        // Qualify one interrupt by enable and a strict priority compare.
        assign qual[i] = pend[i] && en[i] && (prio[i*PRIO_W +: PRIO_W] < cur_prio);
    end

    assign qual_any = |qual;
endmodule

// File: rtl/sw_event_unit.sv
// Module: detects pending rising edges and keeps the event latch.
// Assumes: the latch is not set during an event-mode sleep, since such an
// event wakes the core at once.
module sw_event_unit #(
    parameter int NUM_IRQ = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sev_en,
    input  logic [NUM_IRQ-1:0] pend,
    input  logic               ext_event,
    input  logic               evt_sleep,
    input  logic               clr,
    output logic               ev_now,
    output logic               latch
);
    logic [NUM_IRQ-1:0] pend_q;
    logic               pend_rise;

    // Remember last cycle's pending bits for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend;
    end

    assign pend_rise = |(pend & ~pend_q);
    assign ev_now    = ext_event || (sev_en && pend_rise);

    // Set the latch on a new event, clear it when consumed or used to wake.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch <= 1'b0;
        else
            latch <= (latch && !clr) || (ev_now && !evt_sleep);
    end

    assert_sustained_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_event && pend == $past(pend) && !latch && !clr) |-> !ev_now);
endmodule

// File: rtl/sleep_wake_ctrl.sv
// Module: top of the sleep and wake controller. Decides sleep entry from
// wait requests and exception return, and wake from interrupt, event and
// debug sources. Assumes: request strobes last one cycle; wake is
// combinational in the final sleeping cycle.
module sleep_wake_ctrl
    import sw_pkg::*;
#(
    parameter int NUM_IRQ = 4,
    parameter int PRIO_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr_en,
    input  logic                      reg_wr_priv,
    input  logic [7:0]                reg_wr_data,
    output logic [7:0]                reg_rd_data,
    input  logic                      wfi_req,
    input  logic                      wfe_req,
    input  logic                      exc_ret,
    input  logic [NUM_IRQ-1:0]        irq_pend,
    input  logic [NUM_IRQ-1:0]        irq_en,
    input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
    input  logic [PRIO_W-1:0]         cur_prio,
    input  logic                      ext_event,
    input  logic                      dbg_req,
    output logic                      sleeping,
    output logic                      deep_sleep,
    output logic                      wake
);
    ctrl_t       ctrl;
    sleep_mode_e mode_q;
    logic        sleep_q;
    logic        qual_any, ev_now, latch;
    logic        go_int, go_wfe, consume, go_evt, evt_wake, wake_cond;

    sw_ctrl_reg i_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_priv(reg_wr_priv),
        .wr_data(reg_wr_data), .rd_data(reg_rd_data), .ctrl(ctrl)
    );

    sw_irq_eval #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) i_irq (
        .pend(irq_pend), .en(irq_en), .prio(irq_prio), .cur_prio(cur_prio),
        .qual_any(qual_any)
    );

    sw_event_unit #(.NUM_IRQ(NUM_IRQ)) i_evt (
        .clk(clk), .rst_n(rst_n), .sev_en(ctrl.sev_on_pend), .pend(irq_pend),
        .ext_event(ext_event), .evt_sleep(sleep_q && mode_q == MODE_EVT),
        .clr(consume || evt_wake), .ev_now(ev_now), .latch(latch)
    );

    // Entry decode: wfi first, then wfe, then exception return.
    always_comb begin
        go_int  = !sleep_q && (wfi_req ||
                  (!wfe_req && exc_ret && ctrl.sleep_on_exit));
        go_wfe  = !sleep_q && !wfi_req && wfe_req;
        consume = go_wfe && latch;
        go_evt  = go_wfe && !latch;
    end

    // Wake decode: debug and qualified interrupts always; events in event mode.
    always_comb begin
        wake_cond = dbg_req || qual_any ||
                    (mode_q == MODE_EVT && (ev_now || latch));
        wake      = sleep_q && wake_cond;
        evt_wake  = wake && mode_q == MODE_EVT;
    end

    // Sleep state and the mode it was entered in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sleep_q <= 1'b0;
            mode_q  <= MODE_INT;
        end else if (wake) begin
            sleep_q <= 1'b0;
        end else if (go_int) begin
            sleep_q <= 1'b1;
            mode_q  <= MODE_INT;
        end else if (go_evt) begin
            sleep_q <= 1'b1;
            mode_q  <= MODE_EVT;
        end
    end

    assign sleeping   = sleep_q;
    assign deep_sleep = sleep_q && ctrl.deep_sel;

    assert_wfi_sleeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleeping && wfi_req) |=> sleeping);
    assert_consume_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleeping && !wfi_req && wfe_req && latch && !ev_now) |=> (!sleeping && !latch));
    assert_no_unqual_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && mode_q == MODE_INT && !dbg_req && !qual_any) |-> !wake);
    assert_deep_in_sleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        deep_sleep |-> sleeping);
    assert_wake_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> (!sleeping && !wake));
    assert_dbg_wakes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && dbg_req) |-> wake);
endmodule

// File: tb/test_sleep_wake_ctrl.sv
module test_sleep_wake_ctrl;
    localparam int N  = 4;
    localparam int PW = 3;

    logic clk = 1'b0;
    logic rst_n;
    logic reg_wr_en, reg_wr_priv;
    logic [7:0] reg_wr_data, reg_rd_data;
    logic wfi_req, wfe_req, exc_ret, ext_event, dbg_req;
    logic [N-1:0] irq_pend, irq_en;
    logic [N*PW-1:0] irq_prio;
    logic [PW-1:0] cur_prio;
    logic sleeping, deep_sleep, wake;
    int total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sleep_wake_ctrl #(.NUM_IRQ(N), .PRIO_W(PW)) i_sleep_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_priv(reg_wr_priv),
        .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data), .wfi_req(wfi_req),
        .wfe_req(wfe_req), .exc_ret(exc_ret), .irq_pend(irq_pend), .irq_en(irq_en),
        .irq_prio(irq_prio), .cur_prio(cur_prio), .ext_event(ext_event),
        .dbg_req(dbg_req), .sleeping(sleeping), .deep_sleep(deep_sleep), .wake(wake)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [7:0] v, logic priv);
        reg_wr_en = 1; reg_wr_priv = priv; reg_wr_data = v;
        step();
        reg_wr_en = 0;
    endtask

    task automatic dbg_wake();
        dbg_req = 1; #1;
        chk("R8 dbg wake", wake, 1);
        step(); dbg_req = 0;
        chk("R11 sleeping falls", sleeping, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; reg_wr_en = 0; reg_wr_priv = 0; reg_wr_data = 0;
        wfi_req = 0; wfe_req = 0; exc_ret = 0; ext_event = 0; dbg_req = 0;
        irq_pend = 0; irq_en = 0; irq_prio = 0; cur_prio = 0;
        step(); step();
        rst_n = 1; step();
        chk("R1 reset rd", reg_rd_data, 0);
        chk("R8 reset sleeping", sleeping, 0);
        chk("R10 reset deep", deep_sleep, 0);
        chk("R11 reset wake", wake, 0);

        // R1 sweep of all byte values
        for (int v = 0; v < 256; v++) begin
            wr(8'(v), 1);
            chk("R1 field mask", reg_rd_data, v & 8'h16);
        end
        wr(8'h16, 1);
        wr(8'h00, 0);
        chk("R2 unpriv write ignored", reg_rd_data, 8'h16);
        wr(8'h00, 1);
        chk("R2 priv write", reg_rd_data, 0);

        // R6 exhaustive priority sweep in a wfi sleep
        for (int p = 0; p < 8; p++)
            for (int c = 0; c < 8; c++)
                for (int e = 0; e < 2; e++) begin
                    cur_prio = PW'(c); irq_prio = '0; irq_prio[PW-1:0] = PW'(p);
                    irq_en = '0; irq_en[0] = 1'(e); irq_pend = '0;
                    wfi_req = 1; step(); wfi_req = 0;
                    chk("R3 wfi sleeps", sleeping, 1);
                    irq_pend[0] = 1; #1;
                    chk("R6 prio wake", wake, ((e == 1) && (p < c)) ? 1 : 0);
                    if (e == 1 && p < c) begin
                        step();
                        chk("R11 sleeping falls", sleeping, 0);
                        chk("R11 wake one cycle", wake, 0);
                    end else dbg_wake();
                    irq_pend = '0; step();
                end
        irq_en = 0; irq_prio = 0; cur_prio = 0;

        // R3 wfi ignores ext_event
        wfi_req = 1; step(); wfi_req = 0;
        ext_event = 1; #1;
        chk("R3 wfi ignores event", wake, 0);
        step(); ext_event = 0;
        chk("R3 still sleeping", sleeping, 1);
        // the event set the latch during int sleep; a wfe consumes it
        dbg_wake();
        wfe_req = 1; step(); wfe_req = 0;
        chk("R4 latch consumed stays awake", sleeping, 0);

        // R5/R4 awake event sets latch, then wfe consumes it
        ext_event = 1; step(); ext_event = 0;
        wfe_req = 1; step(); wfe_req = 0;
        chk("R4 wfe with latch set", sleeping, 0);
        wfe_req = 1; step(); wfe_req = 0;
        chk("R4 wfe with latch clear sleeps", sleeping, 1);
        step(); chk("R7 no spurious wake", sleeping, 1);
        ext_event = 1; #1;
        chk("R7 ext event wakes wfe", wake, 1);
        step(); ext_event = 0;
        chk("R11 sleeping falls", sleeping, 0);

        // R7 wfe wakes on qualified interrupt
        wfe_req = 1; step(); wfe_req = 0;
        cur_prio = 3; irq_prio[PW +: PW] = 1; irq_en[1] = 1; irq_pend[1] = 1; #1;
        chk("R6 wfe irq wake", wake, 1);
        step(); irq_pend = 0; irq_en = 0; irq_prio = 0; cur_prio = 0; step();

        // R7 pend edge without event-on-pend: disabled irq does not wake
        wfe_req = 1; step(); wfe_req = 0;
        irq_pend[2] = 1; step();
        chk("R7 no sev no wake", sleeping, 1);
        dbg_wake(); irq_pend = 0; step();

        // R7 with event-on-pend, disabled irq edge wakes; held pend does not
        wr(8'h10, 1);
        wfe_req = 1; step(); wfe_req = 0;
        irq_pend[2] = 1; #1;
        chk("R7 sev edge wakes", wake, 1);
        step();
        wfe_req = 1; step(); wfe_req = 0;
        chk("R7 held pend sleeps", sleeping, 1);
        step(); step();
        chk("R5 held pend no event", sleeping, 1);
        dbg_wake(); irq_pend = 0; step();

        // R5 pend edge while awake sets latch
        irq_pend[3] = 1; step();
        wfe_req = 1; step(); wfe_req = 0;
        chk("R5 pend edge latch consumed", sleeping, 0);
        irq_pend = 0; wr(8'h00, 1);

        // R12 wfi beats wfe, latch kept; requests while asleep ignored
        ext_event = 1; step(); ext_event = 0;
        wfi_req = 1; wfe_req = 1; step(); wfi_req = 0; wfe_req = 0;
        chk("R12 wfi wins", sleeping, 1);
        wfe_req = 1; step(); wfe_req = 0;
        chk("R12 wfe while asleep ignored", sleeping, 1);
        dbg_wake();
        wfe_req = 1; step(); wfe_req = 0;
        chk("R12 latch kept", sleeping, 0);

        // R9 sleep on exit
        exc_ret = 1; step(); exc_ret = 0;
        chk("R9 bit clear no sleep", sleeping, 0);
        wr(8'h02, 1);
        exc_ret = 1; step(); exc_ret = 0;
        chk("R9 exit sleeps", sleeping, 1);
        chk("R10 normal sleep", deep_sleep, 0);
        ext_event = 1; #1;
        chk("R9 exit sleep ignores event", wake, 0);
        step(); ext_event = 0;
        dbg_wake();
        wfe_req = 1; step(); wfe_req = 0;   // consume latch set above

        // R10 deep sleep
        wr(8'h04, 1);
        chk("R10 awake not deep", deep_sleep, 0);
        wfi_req = 1; step(); wfi_req = 0;
        chk("R10 deep", deep_sleep, 1);

        // R8 reset while sleeping
        rst_n = 0; step(); rst_n = 1;
        chk("R8 reset clears sleep", sleeping, 0);
        chk("R1 reset clears reg", reg_rd_data, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule